// File: doc/BRIEF.md
# Half-Duplex Parallel Packet Responder

This block sits at the far end of an 8-bit shared parallel link and answers packets sent by a host adapter. The host owns a direction line: while it is high the host drives the bus and hands the block one byte per data-ready pulse. The block answers each of those pulses with an acknowledge pulse. Each packet starts with a type byte. Next comes a 16-bit payload length, low byte first, and then the payload. The block keeps the payload in a local buffer of up to 512 bytes and then holds the request for local logic to inspect.

Local logic reads the stored payload through a random-access port. It writes its answer into the same buffer and queues a reply with a type and a length. After the host has released the bus, the block sends the reply with the same handshake roles reversed. The block also has an active-low attention output for raising pending event flags. It answers a status-query packet by itself, returning those flags and clearing them. A rising edge on the direction line always restarts reception, so a transaction that breaks off part-way recovers without a reset.

Top module: `pport_endpoint`

## Requirements
- R1: After reset the block is idle: `bus_oe`, `blk_strobe` and `req_valid` are 0, and `attn_n` is 1.
- R2: In receive mode, each rising edge of `host_strobe` while `link_dir` is 1 takes `bus_in` as the next packet byte. The bytes are taken as type, then length bits 7:0, then length bits 15:8, then payload. Each byte taken gives exactly one single-cycle `blk_strobe` pulse. Payload byte i is stored at buffer address i, and `req_valid` rises once the last byte has been taken.
- R3: A packet whose length field is 0 is complete after three bytes.
- R4: A reply starts only when `rsp_push` arrives while a request is held. The reply is sent as `rsp_type`, length bits 7:0, length bits 15:8, and then buffer bytes 0 to `rsp_len`-1. For each byte the block pulses `blk_strobe` and then waits for a `host_strobe` rising edge before moving on. After the last acknowledged byte the block returns to idle.
- R5: `bus_oe` is 1 only while a reply is in progress and `link_dir` is 0.
- R6: A rising edge on `link_dir` in any state abandons the current transaction. It drops `req_valid` and `bus_oe` and starts reception of a new packet at its type byte.
- R7: A nonzero `event_set` sets the matching pending flags, and `attn_n` is 0 whenever any flag is pending.
- R8: A completed request of type 0x01 does not set `req_valid`. The block replies by itself with type 0x01, length 1 and a payload of the pending flags (bit i = flag i). Those flags are cleared at the same time, which returns `attn_n` to 1.
- R9: If the length field exceeds 512, `req_len` reads 512 and `len_err` is 1. Every excess byte is still acknowledged, and the first 512 payload bytes stay stored.
- R10: `rsp_push` outside the held-request state has no effect: no strobe and no bus drive follow. A `host_strobe` edge while `link_dir` is 0 in the held state is not acknowledged and leaves the request unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_dir | input | 1 | High while the host drives the shared bus |
| host_strobe | input | 1 | Host data-ready (receive) or acknowledge (reply) |
| bus_in | input | 8 | Bus value seen from the host |
| bus_out | output | 8 | Reply byte driven toward the host |
| bus_oe | output | 1 | Output enable for `bus_out` |
| blk_strobe | output | 1 | Block acknowledge (receive) or data-ready (reply) pulse |
| attn_n | output | 1 | Active-low attention request |
| req_valid | output | 1 | A received request is held for local logic |
| req_type | output | 8 | Type byte of the held request |
| req_len | output | 10 | Stored payload length, clamped to 512 |
| len_err | output | 1 | Length field of the current request exceeded 512 |
| rd_addr | input | 9 | Local read address into the payload buffer |
| rd_data | output | 8 | Buffer byte at `rd_addr` |
| rsp_wr_en | input | 1 | Local write strobe into the buffer |
| rsp_wr_addr | input | 9 | Local write address |
| rsp_wr_data | input | 8 | Local write data |
| rsp_push | input | 1 | Queue the reply |
| rsp_type | input | 8 | Reply type byte |
| rsp_len | input | 10 | Reply payload length |
| event_set | input | 8 | Pending flags to set |

## Verification
Requests are sent with a few payload shapes: a short payload, an empty one, and one longer than the buffer. These tell correct length decoding and payload placement apart from off-by-one endings and from overflow wrapping into the buffer. Replies are collected byte by byte through the host handshake. That shows whether the block waits for each acknowledge and whether it holds the bus until the request has been released. Direction-line edges in the middle of a request and in the middle of a reply, together with a status query while flags are pending, show whether recovery, the automatic answer and the clearing of flags act independently of local logic.

// File: rtl/pport_pkg.sv
package pport_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RECV,
        ST_HELD,
        ST_SEND
    } ep_state_e;

    typedef enum logic [1:0] {
        PH_KIND,
        PH_LEN_LO,
        PH_LEN_HI,
        PH_BODY
    } rx_phase_e;

    typedef struct packed {
        logic [BYTE_W-1:0] kind;
        logic [15:0]       len;
    } pkt_head_t;

    function automatic logic [15:0] clamp16(input logic [15:0] v, input logic [15:0] lim);
        return (v > lim) ? lim : v;
    endfunction

endpackage

// File: rtl/pport_rise.sv
module pport_rise #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sig,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) prev[i] <= 1'b0;
            else     prev[i] <= sig[i];
        end
        assign rise[i] = sig[i] & ~prev[i];
    end
endmodule

// File: rtl/pport_buffer.sv
module pport_buffer #(
    parameter int unsigned DEPTH  = 512,
    parameter int unsigned ADDR_W = $clog2(DEPTH),
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] ra_addr,
    output logic [DATA_W-1:0] ra_data,
    input  logic [ADDR_W-1:0] rb_addr,
    output logic [DATA_W-1:0] rb_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign ra_data = mem[ra_addr];
    assign rb_data = mem[rb_addr];
endmodule

// File: rtl/pport_flags.sv
module pport_flags #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set,
    input  logic         take,
    output logic [W-1:0] pending
);
    always_ff @(posedge clk) begin
        if (rst)       pending <= '0;
        else if (take) pending <= set;
        else           pending <= pending | set;
    end
endmodule

// File: rtl/pport_endpoint.sv
module pport_endpoint
    import pport_pkg::*;
#(
    parameter int unsigned MAX_PAYLOAD = 512,
    parameter int unsigned FLAG_W      = 8,
    parameter logic [7:0]  STATUS_TYPE = 8'h01,
    parameter int unsigned LEN_W       = $clog2(MAX_PAYLOAD + 1),
    parameter int unsigned ADDR_W      = $clog2(MAX_PAYLOAD)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              link_dir,
    input  logic              host_strobe,
    input  logic [7:0]        bus_in,
    output logic [7:0]        bus_out,
    output logic              bus_oe,
    output logic              blk_strobe,
    output logic              attn_n,
    output logic              req_valid,
    output logic [7:0]        req_type,
    output logic [LEN_W-1:0]  req_len,
    output logic              len_err,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic              rsp_wr_en,
    input  logic [ADDR_W-1:0] rsp_wr_addr,
    input  logic [7:0]        rsp_wr_data,
    input  logic              rsp_push,
    input  logic [7:0]        rsp_type,
    input  logic [LEN_W-1:0]  rsp_len,
    input  logic [FLAG_W-1:0] event_set
);
    localparam logic [15:0] MAX16  = 16'(MAX_PAYLOAD);
    localparam int unsigned IDX_W  = LEN_W + 1;

    ep_state_e         state;
    rx_phase_e         phase;
    pkt_head_t         rx_head;
    logic [15:0]       pcount;
    logic              ack_q;
    logic [7:0]        tx_kind;
    logic [LEN_W-1:0]  tx_len;
    logic              tx_status;
    logic [IDX_W-1:0]  tx_idx;
    logic              tx_pend;
    logic [FLAG_W-1:0] flags;
    logic [FLAG_W-1:0] snap;

    logic [1:0] rise;
    logic       dir_rise, stb_rise;

    pport_rise #(.W(2)) u_rise (
        .clk (clk),
        .rst (rst),
        .sig ({link_dir, host_strobe}),
        .rise(rise)
    );
    assign dir_rise = rise[1];
    assign stb_rise = rise[0];

    logic        rx_take, rx_last, rx_wr, status_done;
    logic [15:0] full_len;

    assign rx_take  = (state == ST_RECV) && link_dir && stb_rise && !dir_rise;
    assign full_len = {bus_in, rx_head.len[7:0]};
    assign rx_last  = ((phase == PH_LEN_HI) && (full_len == 16'd0)) ||
                      ((phase == PH_BODY) && (16'(pcount + 16'd1) == rx_head.len));
    assign rx_wr    = rx_take && (phase == PH_BODY) && (pcount < MAX16);
    assign status_done = rx_take && rx_last && (rx_head.kind == STATUS_TYPE);

    logic              buf_we;
    logic [ADDR_W-1:0] buf_waddr;
    logic [7:0]        buf_wdata;
    logic [ADDR_W-1:0] tx_addr;
    logic [7:0]        tx_mem;

    assign buf_we    = rx_wr || (rsp_wr_en && state != ST_RECV);
    assign buf_waddr = rx_wr ? pcount[ADDR_W-1:0] : rsp_wr_addr;
    assign buf_wdata = rx_wr ? bus_in : rsp_wr_data;
    assign tx_addr   = ADDR_W'(tx_idx - IDX_W'(3));

    pport_buffer #(.DEPTH(MAX_PAYLOAD), .ADDR_W(ADDR_W), .DATA_W(8)) u_buf (
        .clk    (clk),
        .wr_en  (buf_we),
        .wr_addr(buf_waddr),
        .wr_data(buf_wdata),
        .ra_addr(rd_addr),
        .ra_data(rd_data),
        .rb_addr(tx_addr),
        .rb_data(tx_mem)
    );

    pport_flags #(.W(FLAG_W)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .set    (event_set),
        .take   (status_done),
        .pending(flags)
    );

    logic [IDX_W-1:0] tx_last_idx;
    logic [15:0]      tx_len16;
    logic [15:0]      rsp_len_c;
    logic [15:0]      req_len_c;

    assign tx_len16    = 16'(tx_len);
    assign tx_last_idx = IDX_W'(tx_len) + IDX_W'(2);
    assign rsp_len_c   = clamp16(16'(rsp_len), MAX16);
    assign req_len_c   = clamp16(rx_head.len, MAX16);

    always_comb begin
        unique case (tx_idx)
            IDX_W'(0): bus_out = tx_kind;
            IDX_W'(1): bus_out = tx_len16[7:0];
            IDX_W'(2): bus_out = tx_len16[15:8];
            default:   bus_out = tx_status ? 8'(snap) : tx_mem;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            phase     <= PH_KIND;
            rx_head   <= '0;
            pcount    <= '0;
            len_err   <= 1'b0;
            ack_q     <= 1'b0;
            tx_kind   <= '0;
            tx_len    <= '0;
            tx_status <= 1'b0;
            tx_idx    <= '0;
            tx_pend   <= 1'b0;
            snap      <= '0;
        end else begin
            ack_q <= 1'b0;
            if (dir_rise) begin
                state   <= ST_RECV;
                phase   <= PH_KIND;
                pcount  <= '0;
                len_err <= 1'b0;
                tx_pend <= 1'b0;
            end else begin
                unique case (state)
                    ST_RECV: if (rx_take) begin
                        ack_q <= 1'b1;
                        unique case (phase)
                            PH_KIND:   begin rx_head.kind <= bus_in; phase <= PH_LEN_LO; end
                            PH_LEN_LO: begin rx_head.len[7:0] <= bus_in; phase <= PH_LEN_HI; end
                            PH_LEN_HI: begin
                                rx_head.len[15:8] <= bus_in;
                                if (full_len > MAX16) len_err <= 1'b1;
                                phase <= PH_BODY;
                            end
                            PH_BODY:   pcount <= 16'(pcount + 16'd1);
                        endcase
                        if (rx_last) begin
                            if (rx_head.kind == STATUS_TYPE) begin
                                state     <= ST_SEND;
                                tx_kind   <= STATUS_TYPE;
                                tx_len    <= LEN_W'(1);
                                tx_status <= 1'b1;
                                snap      <= flags;
                                tx_idx    <= '0;
                                tx_pend   <= 1'b0;
                            end else begin
                                state <= ST_HELD;
                            end
                        end
                    end
                    ST_HELD: if (rsp_push) begin
                        state     <= ST_SEND;
                        tx_kind   <= rsp_type;
                        tx_len    <= rsp_len_c[LEN_W-1:0];
                        tx_status <= 1'b0;
                        tx_idx    <= '0;
                        tx_pend   <= 1'b0;
                    end
                    ST_SEND: if (!link_dir) begin
                        if (!tx_pend && !ack_q) begin
                            ack_q   <= 1'b1;
                            tx_pend <= 1'b1;
                        end else if (tx_pend && stb_rise) begin
                            tx_pend <= 1'b0;
                            if (tx_idx == tx_last_idx) state <= ST_IDLE;
                            else tx_idx <= IDX_W'(tx_idx + IDX_W'(1));
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign blk_strobe = ack_q;
    assign bus_oe     = (state == ST_SEND) && !link_dir;
    assign req_valid  = (state == ST_HELD);
    assign req_type   = rx_head.kind;
    assign req_len    = req_len_c[LEN_W-1:0];
    assign attn_n     = ~(|flags);

endmodule

// File: rtl/pport_endpoint_chk.sv
module pport_endpoint_chk #(
    parameter int unsigned MAX_PAYLOAD = 512,
    parameter int unsigned FLAG_W      = 8,
    parameter int unsigned LEN_W       = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              link_dir,
    input logic              bus_oe,
    input logic              blk_strobe,
    input logic              attn_n,
    input logic              req_valid,
    input logic [LEN_W-1:0]  req_len,
    input logic [FLAG_W-1:0] event_set
);
    assert_oe_dir_R5: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> !link_dir);

    assert_strobe_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        blk_strobe |=> !blk_strobe);

    assert_dir_restart_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(link_dir) |=> !req_valid);

    assert_attn_R7: assert property (@(posedge clk) disable iff (rst)
        (event_set != '0) |=> !attn_n);

    assert_len_clamp_R9: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (32'(req_len) <= MAX_PAYLOAD));
endmodule

bind pport_endpoint pport_endpoint_chk #(
    .MAX_PAYLOAD(MAX_PAYLOAD),
    .FLAG_W     (FLAG_W),
    .LEN_W      (LEN_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .link_dir  (link_dir),
    .bus_oe    (bus_oe),
    .blk_strobe(blk_strobe),
    .attn_n    (attn_n),
    .req_valid (req_valid),
    .req_len   (req_len),
    .event_set (event_set)
);

// File: tb/sim_pport_endpoint.sv
module sim_pport_endpoint;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       link_dir, host_strobe;
    logic [7:0] bus_in, bus_out;
    logic       bus_oe, blk_strobe, attn_n, req_valid, len_err;
    logic [7:0] req_type;
    logic [9:0] req_len;
    logic [8:0] rd_addr;
    logic [7:0] rd_data;
    logic       rsp_wr_en;
    logic [8:0] rsp_wr_addr;
    logic [7:0] rsp_wr_data;
    logic       rsp_push;
    logic [7:0] rsp_type;
    logic [9:0] rsp_len;
    logic [7:0] event_set;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pport_endpoint u0 (
        .clk(clk), .rst(rst), .link_dir(link_dir), .host_strobe(host_strobe),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .blk_strobe(blk_strobe),
        .attn_n(attn_n), .req_valid(req_valid), .req_type(req_type), .req_len(req_len),
        .len_err(len_err), .rd_addr(rd_addr), .rd_data(rd_data), .rsp_wr_en(rsp_wr_en),
        .rsp_wr_addr(rsp_wr_addr), .rsp_wr_data(rsp_wr_data), .rsp_push(rsp_push),
        .rsp_type(rsp_type), .rsp_len(rsp_len), .event_set(event_set)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
        return 8'(seed + 8'(i * 3));
    endfunction

    // one host byte; returns number of acknowledge pulses seen
    task automatic host_byte(input logic [7:0] b, output int acks);
        acks = 0;
        @(negedge clk); bus_in = b; host_strobe = 1'b1;
        @(negedge clk); host_strobe = 1'b0; if (blk_strobe) acks++;
        @(negedge clk); if (blk_strobe) acks++;
    endtask

    task automatic host_packet(input logic [7:0] kind, input int len, input int sent,
                               input logic [7:0] seed, input string req);
        int a;
        int bad = 0;
        @(negedge clk); link_dir = 1'b1;
        @(negedge clk);
        host_byte(kind, a);          if (a != 1) bad++;
        host_byte(8'(len), a);       if (a != 1) bad++;
        host_byte(8'(len >> 8), a);  if (a != 1) bad++;
        for (int i = 0; i < sent; i++) begin
            host_byte(pat(seed, i), a);
            if (a != 1) bad++;
        end
        check(bad == 0, req, bad, 0);
    endtask

    task automatic end_request();
        @(negedge clk); link_dir = 1'b0;
    endtask

    task automatic host_recv(output logic [7:0] v, output bit ok);
        ok = 1'b0;
        v  = 8'h00;
        for (int t = 0; t < 20 && !ok; t++) begin
            @(negedge clk);
            if (blk_strobe) begin
                ok = bus_oe;
                v  = bus_out;
            end
        end
        host_strobe = 1'b1;
        @(negedge clk); host_strobe = 1'b0;
    endtask

    task automatic local_write(input int addr, input logic [7:0] d);
        @(negedge clk); rsp_wr_en = 1'b1; rsp_wr_addr = 9'(addr); rsp_wr_data = d;
        @(negedge clk); rsp_wr_en = 1'b0;
    endtask

    task automatic local_push(input logic [7:0] t, input int len);
        @(negedge clk); rsp_push = 1'b1; rsp_type = t; rsp_len = 10'(len);
        @(negedge clk); rsp_push = 1'b0;
    endtask

    task automatic expect_reply(input logic [7:0] t, input int len,
                                input logic [7:0] seed, input string req);
        logic [7:0] v;
        bit ok;
        int bad = 0;
        host_recv(v, ok); if (!ok || v != t) bad++;
        host_recv(v, ok); if (!ok || v != 8'(len)) bad++;
        host_recv(v, ok); if (!ok || v != 8'(len >> 8)) bad++;
        for (int i = 0; i < len; i++) begin
            host_recv(v, ok);
            if (!ok || v != pat(seed, i)) bad++;
        end
        check(bad == 0, req, bad, 0);
        repeat (3) @(negedge clk);
        check(!bus_oe && !blk_strobe, req, {bus_oe, blk_strobe}, 0);
    endtask

    task automatic t_reset();
        check(!bus_oe && !blk_strobe && !req_valid && attn_n, "R1 reset state",
              {bus_oe, blk_strobe, req_valid, attn_n}, 1);
    endtask

    task automatic t_basic();
        int bad = 0;
        host_packet(8'h22, 5, 5, 8'h10, "R2 acks per byte");
        end_request();
        @(negedge clk);
        check(req_valid && req_type == 8'h22 && req_len == 10'd5, "R2 header",
              {req_valid, req_type, 6'(0), req_len}, {1'b1, 8'h22, 6'(0), 10'd5});
        for (int i = 0; i < 5; i++) begin
            rd_addr = 9'(i); #1;
            if (rd_data != pat(8'h10, i)) bad++;
        end
        check(bad == 0, "R2 payload stored", bad, 0);
        repeat (5) @(negedge clk);
        check(!blk_strobe && !bus_oe && req_valid, "R4 waits for push",
              {blk_strobe, bus_oe, req_valid}, 1);
        for (int i = 0; i < 3; i++) local_write(i, pat(8'h80, i));
        local_push(8'h33, 3);
        expect_reply(8'h33, 3, 8'h80, "R4 reply bytes");
        check(!req_valid, "R4 back to idle", req_valid, 0);
    endtask

    task automatic t_zero();
        host_packet(8'h40, 0, 0, 8'h00, "R3 three byte acks");
        end_request();
        @(negedge clk);
        check(req_valid && req_len == 0 && req_type == 8'h40, "R3 zero length done",
              {req_valid, req_len}, {1'b1, 10'd0});
        local_push(8'h41, 0);
        expect_reply(8'h41, 0, 8'h00, "R3 zero length reply");
    endtask

    task automatic t_long();
        host_packet(8'h50, 520, 520, 8'h07, "R9 excess bytes acked");
        end_request();
        @(negedge clk);
        check(req_valid && req_len == 10'd512 && len_err, "R9 clamp and error",
              {req_valid, len_err, req_len}, {1'b1, 1'b1, 10'd512});
        rd_addr = 9'd511; #1;
        check(rd_data == pat(8'h07, 511), "R9 last stored byte", rd_data, pat(8'h07, 511));
        rd_addr = 9'd0; #1;
        check(rd_data == pat(8'h07, 0), "R9 no wrap overwrite", rd_data, pat(8'h07, 0));
        local_push(8'h51, 0);
        expect_reply(8'h51, 0, 8'h00, "R9 reply after long");
    endtask

    task automatic t_abort();
        logic [7:0] v;
        bit ok;
        host_packet(8'h60, 10, 2, 8'h20, "R6 partial request");
        end_request();
        host_packet(8'h66, 1, 1, 8'h99, "R6 restarted request");
        end_request();
        @(negedge clk);
        rd_addr = 9'd0; #1;
        check(req_valid && req_type == 8'h66 && req_len == 1 && rd_data == 8'h99,
              "R6 recover mid-request", {req_type, rd_data}, {8'h66, 8'h99});
        for (int i = 0; i < 4; i++) local_write(i, pat(8'h30, i));
        local_push(8'h67, 4);
        host_recv(v, ok);
        host_recv(v, ok);
        @(negedge clk); link_dir = 1'b1;
        #1;
        check(!bus_oe, "R5 no drive when dir high", bus_oe, 0);
        @(negedge clk);
        check(!req_valid && !bus_oe, "R6 reply abandoned", {req_valid, bus_oe}, 0);
        @(negedge clk); link_dir = 1'b0;
        host_packet(8'h70, 2, 2, 8'h44, "R6 fresh request");
        end_request();
        @(negedge clk);
        check(req_valid && req_type == 8'h70 && req_len == 2, "R6 new request held",
              {req_valid, req_type}, {1'b1, 8'h70});
        local_push(8'h71, 0);
        expect_reply(8'h71, 0, 8'h00, "R6 reply after recover");
    endtask

    task automatic t_status();
        logic [7:0] v;
        bit ok;
        int bad = 0;
        @(negedge clk); event_set = 8'h05;
        @(negedge clk); event_set = 8'h00;
        check(!attn_n, "R7 attention raised", attn_n, 0);
        host_packet(8'h01, 0, 0, 8'h00, "R8 status request acks");
        check(!bus_oe, "R5 held off while dir high", bus_oe, 0);
        end_request();
        host_recv(v, ok); if (!ok || v != 8'h01) bad++;
        host_recv(v, ok); if (!ok || v != 8'h01) bad++;
        host_recv(v, ok); if (!ok || v != 8'h00) bad++;
        host_recv(v, ok); if (!ok || v != 8'h05) bad++;
        check(bad == 0, "R8 status reply", bad, 0);
        repeat (2) @(negedge clk);
        check(attn_n && !req_valid, "R8 flags cleared", {attn_n, req_valid}, 2'b10);
    endtask

    task automatic t_ignore();
        int seen = 0;
        local_push(8'h90, 2);
        repeat (6) begin
            @(negedge clk);
            if (blk_strobe || bus_oe) seen++;
        end
        check(seen == 0, "R10 push while idle", seen, 0);
        host_packet(8'h91, 1, 1, 8'h55, "R10 setup request");
        end_request();
        @(negedge clk); bus_in = 8'hEE; host_strobe = 1'b1;
        @(negedge clk); host_strobe = 1'b0; if (blk_strobe) seen++;
        @(negedge clk); if (blk_strobe) seen++;
        rd_addr = 9'd0; #1;
        check(seen == 0 && req_valid && req_type == 8'h91 && req_len == 1 && rd_data == 8'h55,
              "R10 strobe with dir low", {seen[7:0], rd_data}, {8'h00, 8'h55});
        local_push(8'h92, 0);
        expect_reply(8'h92, 0, 8'h00, "R10 reply after ignore");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; link_dir = 1'b0; host_strobe = 1'b0; bus_in = '0;
        rd_addr = '0; rsp_wr_en = 1'b0; rsp_wr_addr = '0; rsp_wr_data = '0;
        rsp_push = 1'b0; rsp_type = '0; rsp_len = '0; event_set = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_zero();
        t_long();
        t_abort();
        t_status();
        t_ignore();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule